// File: doc/BRIEF.md
# SPI Master Receive Engine

This block is an SPI bus master built for reception that needs no software pacing. A host drives a small set of control inputs and writes or reads one 8-bit data port. The block generates the serial clock, drives the outgoing data line, and samples either the dedicated input line or a shared single-wire line.

The mode comes from the control inputs. In transmit mode (full duplex, or single-wire with the output driver on), each frame is started by a host write. A write that lands before the running frame ends continues the clock with no gap. A missing write lets the bus go idle between frames. In receive mode (receive-only, or single-wire with the output driver off), enabling the master starts a free-running clock. Frames then arrive back to back with no writes at all until the host clears enable.

Status outputs report the following: a received frame is waiting, the transmit holding register is empty, a frame was lost, and the bus is active.

Top module: `spi_rx_master`

## Requirements
- R1: After reset, rxFull=0, txEmpty=1, overrun=0, busy=0 and sck=0 (with cpol held at 0).
- R2: Receive mode is rxOnly=1, or biMode=1 with biOut=0. In receive mode, raising enable sets busy on the next clock edge. Frames are then received continuously with no host write. Bits arrive most significant first. mosiOe is 0 in this mode.
- R3: In receive mode, busy stays 1 with no gap while enable is held. After enable clears, the frame in flight completes and is latched with rxFull set. Then busy falls, sck rests at cpol, and no further frame starts.
- R4: Each completed frame sets rxFull. hostRdata shows the newest frame. A hostRd pulse clears rxFull.
- R5: A frame that completes while rxFull is still 1 and no read occurs in that cycle replaces the buffer and sets overrun. A hostRd pulse clears overrun.
- R6: With biMode=1 and biOut=0, received bits come from lineIn and miso is ignored. mosiOe is 0.
- R7: In transmit mode, a write made while txEmpty=1 and before the running frame ends produces the next frame with busy held at 1 and no clock gap.
- R8: In transmit mode with nothing written, no frame starts. After the last queued frame, busy falls and sck rests at cpol until the next write.
- R9: A write in idle transmit mode shows txEmpty=0 on the following cycle. txEmpty returns to 1 one cycle later, in the same cycle busy rises, as the byte moves into the shifter.
- R10: sck idles at cpol. With cpha=0, data is sampled on the edge leaving idle. With cpha=1, it is sampled on the edge returning to idle. All four combinations deliver bytes intact in both directions. One sck period is CLK_DIV system clocks.
- R11: In transmit mode, mosiOe is 1 and miso is received at the same time as mosi is sent, so hostRdata holds the last received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master enable |
| rxOnly | input | 1 | Receive-only select |
| biMode | input | 1 | Single shared data line select |
| biOut | input | 1 | Output driver enable in single-line mode |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase (0: sample on leading edge) |
| hostWr | input | 1 | Data port write strobe |
| hostWdata | input | 8 | Byte to send |
| hostRd | input | 1 | Data port read strobe |
| hostRdata | output | 8 | Last received byte |
| rxFull | output | 1 | Received byte waiting |
| txEmpty | output | 1 | Transmit holding register empty |
| overrun | output | 1 | A received byte was lost |
| busy | output | 1 | Bus active |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Outgoing data |
| mosiOe | output | 1 | Output driver enable for mosi |
| miso | input | 1 | Incoming data, dedicated line |
| lineIn | input | 1 | Incoming data, shared line |

## Verification
The properties take for granted that cpol, cpha and the mode inputs are changed only while busy is low. They also assume that hostWr and hostRd are single-cycle pulses. The stimulus changes mode and clock settings only after enable is cleared and busy has fallen. After each change it waits a few cycles and then resynchronises its slave model, so the clock-level change is not counted as a data edge. Random bytes are sent across all four clock settings, and directed runs cover overrun, the stop at a frame boundary and the back-to-back write window.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int FRAME_W = 8;
  localparam int EDGES   = 2 * FRAME_W;

  typedef struct packed {
    logic loadShift;  // move holding register into the shifter
    logic shiftOut;   // present next outgoing bit
    logic sampleIn;   // capture incoming bit
    logic frameDone;  // last clock edge of a frame
  } strobe_t;
endpackage

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    rxMode,
  input  logic    cpol,
  input  logic    cpha,
  input  logic    holdValid,
  output strobe_t stb,
  output logic    busy,
  output logic    sck
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EW   = $clog2(EDGES);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t        state;
  logic [CW-1:0] halfCnt;
  logic [EW-1:0] edgeIdx;
  logic          sckReg;
  logic          halfEnd, edgeTick, lastEdge, goNext, startNow;

  always_comb begin
    halfEnd  = (halfCnt == CW'(HALF - 1));
    edgeTick = (state == S_RUN) && halfEnd;
    lastEdge = edgeTick && (edgeIdx == EW'(EDGES - 1));
    goNext   = rxMode ? enable : (enable && holdValid);
    startNow = (state == S_IDLE) && goNext;
    stb.frameDone = lastEdge;
    stb.loadShift = !rxMode && (startNow || (lastEdge && goNext));
    stb.sampleIn  = edgeTick && (edgeIdx[0] == cpha);
    stb.shiftOut  = edgeTick && (edgeIdx[0] != cpha) && !lastEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfCnt <= '0;
      edgeIdx <= '0;
      sckReg  <= 1'b0;
    end else if (state == S_IDLE) begin
      sckReg  <= cpol;
      halfCnt <= '0;
      edgeIdx <= '0;
      if (startNow) state <= S_RUN;
    end else if (halfEnd) begin
      halfCnt <= '0;
      sckReg  <= ~sckReg;
      edgeIdx <= edgeIdx + 1'b1;
      if (lastEdge && !goNext) state <= S_IDLE;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign busy = (state == S_RUN);
  assign sck  = sckReg;

  // R8 / R3: an idle bus rests at the polarity level
  a_r8_sck_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |=> (sck == $past(cpol)));

  // R2: receive mode starts at once when enabled
  a_r2_rx_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && enable && rxMode) |=> busy);

  // R3: reception stays continuous while enabled
  a_r3_rx_continuous: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameDone && rxMode && enable) |=> busy);

  // R7: a refilled holding register keeps the bus running
  a_r7_tx_continuous: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameDone && !rxMode && enable && holdValid) |=> busy);
endmodule

// File: rtl/spi_rx_data.sv
module spi_rx_data
  import spi_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               cpha,
  input  logic               sdIn,
  input  logic               hostWr,
  input  logic [FRAME_W-1:0] hostWdata,
  input  logic               hostRd,
  output logic [FRAME_W-1:0] hostRdata,
  output logic               rxFull,
  output logic               txEmpty,
  output logic               overrun,
  output logic               holdValid,
  output logic               mosiBit
);
  logic [FRAME_W-1:0] txHold, txShift, rxShift, rxBuf, nextRx;

  always_comb nextRx = stb.sampleIn ? {rxShift[FRAME_W-2:0], sdIn} : rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxBuf   <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      rxShift <= nextRx;
      if (stb.frameDone) rxBuf <= nextRx;
      if (stb.frameDone)  rxFull <= 1'b1;
      else if (hostRd)    rxFull <= 1'b0;
      if (stb.frameDone && rxFull && !hostRd) overrun <= 1'b1;
      else if (hostRd)                        overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold    <= '0;
      holdValid <= 1'b0;
      txShift   <= '0;
      mosiBit   <= 1'b0;
    end else begin
      if (hostWr) begin
        txHold    <= hostWdata;
        holdValid <= 1'b1;
      end else if (stb.loadShift) begin
        holdValid <= 1'b0;
      end
      if (stb.loadShift) begin
        if (!cpha) begin
          mosiBit <= txHold[FRAME_W-1];
          txShift <= {txHold[FRAME_W-2:0], 1'b0};
        end else begin
          txShift <= txHold;
        end
      end else if (stb.shiftOut) begin
        mosiBit <= txShift[FRAME_W-1];
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign hostRdata = rxBuf;
  assign txEmpty   = !holdValid;

  // R4: a finished frame always leaves data waiting
  a_r4_full_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |=> rxFull);

  // R5: a lost frame implies the buffer still holds unread data
  a_r5_overrun_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> rxFull);

  // R4 / R5: a read with no frame finishing empties both flags
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !stb.frameDone) |=> (!rxFull && !overrun));

  // R9: a write always fills the holding register
  a_r9_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> !txEmpty);
endmodule

// File: rtl/spi_rx_master.sv
module spi_rx_master
  import spi_rx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       rxOnly,
  input  logic       biMode,
  input  logic       biOut,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       hostWr,
  input  logic [7:0] hostWdata,
  input  logic       hostRd,
  output logic [7:0] hostRdata,
  output logic       rxFull,
  output logic       txEmpty,
  output logic       overrun,
  output logic       busy,
  output logic       sck,
  output logic       mosi,
  output logic       mosiOe,
  input  logic       miso,
  input  logic       lineIn
);
  strobe_t stb;
  logic    rxMode, sdIn, holdValid;

  assign rxMode = rxOnly || (biMode && !biOut);
  assign sdIn   = biMode ? lineIn : miso;
  assign mosiOe = !rxMode;

  spi_rx_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .rxMode(rxMode),
    .cpol(cpol), .cpha(cpha), .holdValid(holdValid),
    .stb(stb), .busy(busy), .sck(sck)
  );

  spi_rx_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .cpha(cpha), .sdIn(sdIn),
    .hostWr(hostWr), .hostWdata(hostWdata), .hostRd(hostRd),
    .hostRdata(hostRdata), .rxFull(rxFull), .txEmpty(txEmpty),
    .overrun(overrun), .holdValid(holdValid), .mosiBit(mosi)
  );
endmodule

// File: tb/spi_rx_master_tb.sv
module spi_rx_master_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, rxOnly = 0, biMode = 0, biOut = 0, cpol = 0, cpha = 0;
  logic hostWr = 0, hostRd = 0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic rxFull, txEmpty, overrun, busy, sck, mosi, mosiOe;
  logic miso, lineIn, junk = 0;

  int total = 0, bad = 0, busyDrops = 0;
  logic watchBusy = 0;

  // slave model
  logic [7:0] sTx [16];
  logic [7:0] sRx [16];
  logic [7:0] mTx [16];
  logic [3:0] sIdx = 0, sRxIdx = 0;
  logic [2:0] sBit = 0;
  logic [7:0] sAcc = 0;
  logic       slaveBit, isSample;

  always #5 clk = ~clk;

  spi_rx_master u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rxOnly(rxOnly), .biMode(biMode),
    .biOut(biOut), .cpol(cpol), .cpha(cpha), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRd(hostRd), .hostRdata(hostRdata),
    .rxFull(rxFull), .txEmpty(txEmpty), .overrun(overrun), .busy(busy),
    .sck(sck), .mosi(mosi), .mosiOe(mosiOe), .miso(miso), .lineIn(lineIn)
  );

  assign slaveBit = sTx[sIdx][~sBit];
  assign miso   = biMode ? junk : slaveBit;
  assign lineIn = biMode ? slaveBit : junk;

  always @(sck) begin
    isSample = ((sck != cpol) != cpha);
    if (isSample) begin
      sAcc = {sAcc[6:0], mosi};
      if (sBit == 3'd7) begin
        sRx[sRxIdx] = sAcc;
        sRxIdx = sRxIdx + 1'b1;
        sIdx = sIdx + 1'b1;
      end
      sBit = sBit + 1'b1;
    end
  end

  always @(negedge clk) begin
    junk <= 1'($urandom);
    if (watchBusy && !busy) busyDrops++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slaveReset();
    sIdx = 0; sBit = 0; sRxIdx = 0; sAcc = 0;
  endtask

  task automatic setMode(input logic ro, input logic bm, input logic bo,
                         input logic pol, input logic pha);
    rxOnly = ro; biMode = bm; biOut = bo; cpol = pol; cpha = pha;
    tick(3);
    slaveReset();
  endtask

  task automatic hostWrite(input logic [7:0] b);
    hostWr = 1; hostWdata = b;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic hostRead(output logic [7:0] b);
    b = hostRdata;
    hostRd = 1;
    @(negedge clk);
    hostRd = 0;
  endtask

  task automatic waitFull();
    for (int i = 0; i < 400 && !rxFull; i++) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic quiesce();
    logic [7:0] d;
    enable = 0;
    waitIdle();
    tick(2);
    if (rxFull) hostRead(d);
  endtask

  // receive n frames in receive mode, then stop and collect the last one
  task automatic rxCollect(input int n, input string req);
    logic [7:0] got;
    enable = 1;
    @(negedge clk);
    chk("R2 busy right after enable", int'(busy), 1);
    busyDrops = 0;
    watchBusy = 1;
    for (int k = 0; k < n; k++) begin
      waitFull();
      chk("R4 rxFull on frame", int'(rxFull), 1);
      hostRead(got);
      chk(req, int'(got), int'(sTx[k]));
    end
    watchBusy = 0;
    chk("R3 busy without gap", busyDrops, 0);
    enable = 0;
    waitIdle();
    chk("R3 sck at idle level", int'(sck), int'(cpol));
    chk("R3 frame in flight latched", int'(rxFull), 1);
    hostRead(got);
    chk("R3 frame in flight data", int'(got), int'(sTx[n]));
    chk("R4 read clears rxFull", int'(rxFull), 0);
    tick(6);
    chk("R3 no frame after stop", int'(busy), 0);
  endtask

  task automatic txGapped(input int n, input string req);
    enable = 1;
    for (int k = 0; k < n; k++) begin
      hostWrite(mTx[k]);
      tick(1);
      chk("R8 frame starts after write", int'(busy), 1);
      waitIdle();
      chk("R8 sck idle in gap", int'(sck), int'(cpol));
      chk(req, int'(sRx[k]), int'(mTx[k]));
    end
    enable = 0;
  endtask

  task automatic runAll();
    logic [7:0] d;
    rstN = 0;
    tick(4);
    // R1 reset state
    chk("R1 rxFull", int'(rxFull), 0);
    chk("R1 txEmpty", int'(txEmpty), 1);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 sck", int'(sck), 0);
    rstN = 1;
    tick(2);

    // R2 / R10: receive-only, idle-high clock, sample on return edge
    setMode(1, 0, 0, 1, 1);
    for (int k = 0; k < 16; k++) sTx[k] = 8'hA1 + 8'(k);
    chk("R2 driver off in receive-only", int'(mosiOe), 0);
    rxCollect(3, "R2 byte sequence");
    quiesce();

    // R5 overrun
    setMode(1, 0, 0, 0, 0);
    for (int k = 0; k < 16; k++) sTx[k] = 8'h10 + 8'(k);
    enable = 1;
    waitFull();
    tick(34);
    chk("R5 overrun set", int'(overrun), 1);
    chk("R5 buffer replaced", int'(hostRdata), int'(sTx[1]));
    hostRead(d);
    chk("R5 read clears overrun", int'(overrun), 0);
    chk("R4 read clears rxFull", int'(rxFull), 0);
    quiesce();

    // R6 single-line receive
    setMode(0, 1, 0, 0, 1);
    for (int k = 0; k < 16; k++) sTx[k] = 8'($urandom);
    chk("R6 driver off", int'(mosiOe), 0);
    rxCollect(3, "R6 shared line data");
    quiesce();

    // R9 / R8 / R11 transmit idle behaviour
    setMode(0, 0, 0, 0, 0);
    enable = 1;
    tick(2);
    chk("R8 no frame without write", int'(busy), 0);
    chk("R11 driver on", int'(mosiOe), 1);
    chk("R9 txEmpty idle", int'(txEmpty), 1);
    hostWrite(8'h5C);
    chk("R9 txEmpty after write", int'(txEmpty), 0);
    chk("R9 not yet busy", int'(busy), 0);
    tick(1);
    chk("R9 txEmpty after load", int'(txEmpty), 1);
    chk("R9 busy at load", int'(busy), 1);
    waitIdle();
    chk("R8 byte sent", int'(sRx[0]), 8'h5C);
    tick(8);
    chk("R8 stays idle", int'(busy), 0);
    quiesce();

    // R7 / R11 continuous transmit
    setMode(0, 0, 0, 1, 0);
    for (int k = 0; k < 16; k++) begin
      mTx[k] = 8'($urandom);
      sTx[k] = 8'($urandom);
    end
    enable = 1;
    busyDrops = 0;
    hostWrite(mTx[0]);
    for (int k = 1; k < 5; k++) begin
      for (int i = 0; i < 400 && !txEmpty; i++) @(negedge clk);
      watchBusy = 1;
      hostWrite(mTx[k]);
    end
    for (int i = 0; i < 400 && !txEmpty; i++) @(negedge clk);
    watchBusy = 0;
    waitIdle();
    chk("R7 no busy gap", busyDrops, 0);
    for (int k = 0; k < 5; k++) chk("R7 byte order", int'(sRx[k]), int'(mTx[k]));
    chk("R11 duplex receive", int'(hostRdata), int'(sTx[4]));
    chk("R5 overrun unread", int'(overrun), 1);
    quiesce();

    // R10 all clock settings, random data
    for (int c = 0; c < 4; c++) begin
      setMode(1, 0, 0, 1'(c >> 1), 1'(c));
      for (int k = 0; k < 16; k++) sTx[k] = 8'($urandom);
      rxCollect(3, "R10 receive mode data");
      quiesce();
      setMode(0, 0, 0, 1'(c >> 1), 1'(c));
      for (int k = 0; k < 16; k++) mTx[k] = 8'($urandom);
      txGapped(2, "R10 transmit mode data");
      quiesce();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule